// File: doc/BRIEF.md
# Segmented Backplane Window Mapper

This block sits on the card side of a host link and lets a host reach any 4 KiB core region of a 32-bit internal backplane through a 2 KiB memory aperture. The host chooses the target region by programming three byte-wide base-address registers. Together they hold backplane address bits 31:12. A one-bit segment register selects the lower or upper 2 KiB half of that region. Host software that wants a window offset of 0x800 or more selects segment 1 and presents the offset minus 0x800. Lower offsets use segment 0.

Host aperture accesses may be 8, 16 or 32 bits wide. Each is turned into backplane requests on a 16-bit valid/ready interface at base + {segment, offset}. A 32-bit access becomes two 16-bit requests, low half first. The host access stalls until the backplane has accepted every request. The window settings are captured when an access starts. Configuration writes made during an access therefore only affect the next one. A side output reports which core index the current base selects, relative to a fixed enumeration base, with 4 KiB per core.

Top module: `bpwin_mapper`

## Requirements
- R1: After reset all three address registers and the segment register read 0, `bp_valid` and `hst_done` are low, and `win_core` equals (0 - ENUM_BASE) >> 12 modulo 2^20 (0xE8000 for the default base).
- R2: Configuration offset 0x2E stores window address bits 15:12 in its low four bits. Its readback returns those four bits with the upper nibble zero.
- R3: Offset 0x30 holds address bits 23:16 and offset 0x32 holds bits 31:24. Both read back exactly as written. Any other offset reads 0x00, and writing it changes nothing.
- R4: Segment register offset 0x34 accepts only the written values 0 and 1. Any other value is ignored and the register keeps its old value. Readback equals the last accepted value.
- R5: `hst_size` 0 means 8-bit and 1 means 16-bit. Either size issues one backplane request at address {bits 31:12 from the registers, segment, `hst_off`[10:0]}. `bp_half` is 0 for 8-bit and 1 for 16-bit, and `bp_wdata` carries `hst_wdata`[15:0].
- R6: `hst_size` 2 means 32-bit. It issues a 16-bit request at the computed address carrying `hst_wdata`[15:0], then one at address+2 carrying `hst_wdata`[31:16]. A read returns {second `bp_rdata`, first `bp_rdata`}.
- R7: Reads are zero-extended. An 8-bit read returns `bp_rdata`[7:0] in bits 7:0, and a 16-bit read returns `bp_rdata`[15:0] in bits 15:0.
- R8: While `bp_ready` is low, `bp_valid` stays high with stable address and data. `hst_done` pulses for one cycle, in the cycle after the last request is accepted.
- R9: A configuration write made while an access is in progress does not change any request of that access. The next access uses the new settings.
- R10: `win_core` equals (register base - ENUM_BASE) >> 12, truncated to 20 bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_sel | input | 1 | Configuration access strobe |
| cfg_wr | input | 1 | 1 = configuration write, 0 = read |
| cfg_addr | input | 8 | Configuration register offset |
| cfg_wdata | input | 8 | Configuration write byte |
| cfg_rdata | output | 8 | Configuration read byte |
| hst_req | input | 1 | Aperture access request, held until done |
| hst_wr | input | 1 | 1 = aperture write |
| hst_size | input | 2 | 0 = 8-bit, 1 = 16-bit, 2 = 32-bit |
| hst_off | input | 11 | Offset inside the 2 KiB aperture |
| hst_wdata | input | 32 | Aperture write data |
| hst_rdata | output | 32 | Aperture read data, valid with hst_done |
| hst_done | output | 1 | One-cycle completion pulse |
| bp_valid | output | 1 | Backplane request valid |
| bp_ready | input | 1 | Backplane accepts request |
| bp_wr | output | 1 | Backplane request is a write |
| bp_half | output | 1 | 1 = 16-bit request, 0 = 8-bit |
| bp_addr | output | 32 | Backplane byte address |
| bp_wdata | output | 16 | Backplane write data |
| bp_rdata | input | 16 | Backplane read data |
| win_core | output | 20 | Core index selected by the base registers |

## Verification
The bench builds the block with the default enumeration base 0x18000000 and the combinational configuration-readback variant. With these values, core indices near 0 and the wrapped reset value of `win_core` can be reached directly. Backplane latency in the bench model ranges from 0 to 7 cycles. Seven cycles is long enough to place four configuration writes inside a single 32-bit access. That check shows the latched window settings hold across both halves of the access.

// File: rtl/bpwin_pkg.sv
package bpwin_pkg;
   typedef enum logic [1:0] {
      HSZ_BYTE = 2'd0,
      HSZ_HALF = 2'd1,
      HSZ_WORD = 2'd2
   } hsize_e;

   typedef enum logic [1:0] {
      SQ_IDLE = 2'd0,
      SQ_BUSY = 2'd1,
      SQ_RESP = 2'd2
   } seq_state_e;
endpackage

// File: rtl/bpwin_cfg_regs.sv
module bpwin_cfg_regs #(
   parameter logic [7:0] REG_ALO  = 8'h2E,
   parameter logic [7:0] REG_AMID = 8'h30,
   parameter logic [7:0] REG_AHI  = 8'h32,
   parameter logic [7:0] REG_SEG  = 8'h34,
   parameter bit         RD_REG   = 1'b0,
   localparam int        BASE_W   = 20
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_sel,
   input  logic              cfg_wr,
   input  logic [7:0]        cfg_addr,
   input  logic [7:0]        cfg_wdata,
   output logic [7:0]        cfg_rdata,
   output logic [BASE_W-1:0] win_base,
   output logic              win_seg
);
   logic [3:0] alo_q;
   logic [7:0] amid_q;
   logic [7:0] ahi_q;
   logic       seg_q;
   logic [7:0] rd_mux;
   logic       wr_hit;

   assign wr_hit = cfg_sel && cfg_wr;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         alo_q  <= '0;
         amid_q <= '0;
         ahi_q  <= '0;
         seg_q  <= 1'b0;
      end else if (wr_hit) begin
         if (cfg_addr == REG_ALO)  alo_q  <= cfg_wdata[3:0];
         if (cfg_addr == REG_AMID) amid_q <= cfg_wdata;
         if (cfg_addr == REG_AHI)  ahi_q  <= cfg_wdata;
         if (cfg_addr == REG_SEG && cfg_wdata[7:1] == 7'd0) seg_q <= cfg_wdata[0];
      end
   end

   always_comb begin
      rd_mux = 8'h00;
      if (cfg_addr == REG_ALO)  rd_mux = {4'h0, alo_q};
      if (cfg_addr == REG_AMID) rd_mux = amid_q;
      if (cfg_addr == REG_AHI)  rd_mux = ahi_q;
      if (cfg_addr == REG_SEG)  rd_mux = {7'd0, seg_q};
   end

   generate
      if (RD_REG) begin : g_rd_flop
         logic [7:0] rd_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                 rd_q <= 8'h00;
            else if (cfg_sel && !cfg_wr) rd_q <= rd_mux;
         end
         assign cfg_rdata = rd_q;
      end else begin : g_rd_comb
         assign cfg_rdata = (cfg_sel && !cfg_wr) ? rd_mux : 8'h00;
      end
   endgenerate

   assign win_base = {ahi_q, amid_q, alo_q};
   assign win_seg  = seg_q;
endmodule

// File: rtl/bpwin_seq.sv
module bpwin_seq
   import bpwin_pkg::*;
#(
   parameter int ADDR_W = 32,
   parameter int APER_W = 11,
   localparam int BASE_W = ADDR_W - APER_W - 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [BASE_W-1:0] win_base,
   input  logic              win_seg,
   input  logic              hst_req,
   input  logic              hst_wr,
   input  logic [1:0]        hst_size,
   input  logic [APER_W-1:0] hst_off,
   input  logic [31:0]       hst_wdata,
   output logic [31:0]       hst_rdata,
   output logic              hst_done,
   output logic              bp_valid,
   input  logic              bp_ready,
   output logic              bp_wr,
   output logic              bp_half,
   output logic [ADDR_W-1:0] bp_addr,
   output logic [15:0]       bp_wdata,
   input  logic [15:0]       bp_rdata
);
   seq_state_e        st_q;
   hsize_e            sz_q;
   logic              hi_q;
   logic              wr_q;
   logic [ADDR_W-1:0] addr_q;
   logic [31:0]       wd_q;
   logic [15:0]       lo_q;
   logic [31:0]       rd_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q   <= SQ_IDLE;
         sz_q   <= HSZ_BYTE;
         hi_q   <= 1'b0;
         wr_q   <= 1'b0;
         addr_q <= '0;
         wd_q   <= '0;
         lo_q   <= '0;
         rd_q   <= '0;
      end else begin
         unique case (st_q)
            SQ_IDLE: if (hst_req) begin
               addr_q <= {win_base, win_seg, hst_off};
               sz_q   <= hst_size[1] ? HSZ_WORD : hsize_e'({1'b0, hst_size[0]});
               wr_q   <= hst_wr;
               wd_q   <= hst_wdata;
               hi_q   <= 1'b0;
               st_q   <= SQ_BUSY;
            end
            SQ_BUSY: if (bp_ready) begin
               if (sz_q == HSZ_WORD && !hi_q) begin
                  hi_q <= 1'b1;
                  lo_q <= bp_rdata;
               end else begin
                  st_q <= SQ_RESP;
                  unique case (sz_q)
                     HSZ_BYTE: rd_q <= {24'd0, bp_rdata[7:0]};
                     HSZ_HALF: rd_q <= {16'd0, bp_rdata};
                     default:  rd_q <= {bp_rdata, lo_q};
                  endcase
               end
            end
            default: st_q <= SQ_IDLE;
         endcase
      end
   end

   assign bp_valid  = (st_q == SQ_BUSY);
   assign bp_wr     = wr_q;
   assign bp_half   = (sz_q != HSZ_BYTE);
   assign bp_addr   = addr_q + (hi_q ? ADDR_W'(2) : '0);
   assign bp_wdata  = hi_q ? wd_q[31:16] : wd_q[15:0];
   assign hst_done  = (st_q == SQ_RESP);
   assign hst_rdata = rd_q;
endmodule

// File: rtl/bpwin_mapper.sv
module bpwin_mapper #(
   parameter logic [31:0] ENUM_BASE = 32'h1800_0000,
   parameter int          ADDR_W    = 32,
   parameter int          APER_W    = 11,
   parameter logic [7:0]  REG_ALO   = 8'h2E,
   parameter logic [7:0]  REG_AMID  = 8'h30,
   parameter logic [7:0]  REG_AHI   = 8'h32,
   parameter logic [7:0]  REG_SEG   = 8'h34,
   parameter bit          RD_REG    = 1'b0,
   localparam int         CORE_W    = APER_W + 1,
   localparam int         BASE_W    = ADDR_W - CORE_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_sel,
   input  logic              cfg_wr,
   input  logic [7:0]        cfg_addr,
   input  logic [7:0]        cfg_wdata,
   output logic [7:0]        cfg_rdata,
   input  logic              hst_req,
   input  logic              hst_wr,
   input  logic [1:0]        hst_size,
   input  logic [APER_W-1:0] hst_off,
   input  logic [31:0]       hst_wdata,
   output logic [31:0]       hst_rdata,
   output logic              hst_done,
   output logic              bp_valid,
   input  logic              bp_ready,
   output logic              bp_wr,
   output logic              bp_half,
   output logic [ADDR_W-1:0] bp_addr,
   output logic [15:0]       bp_wdata,
   input  logic [15:0]       bp_rdata,
   output logic [BASE_W-1:0] win_core
);
   generate
      if (ADDR_W != 32 || BASE_W != 20) begin : g_bad_geom
         $error("bpwin_mapper: three byte registers span exactly address bits 31:12");
      end
      if (ENUM_BASE[CORE_W-1:0] != '0) begin : g_bad_base
         $error("bpwin_mapper: enumeration base must be core-size aligned");
      end
   endgenerate

   logic [BASE_W-1:0] win_base;
   logic              win_seg;

   bpwin_cfg_regs #(
      .REG_ALO (REG_ALO),
      .REG_AMID(REG_AMID),
      .REG_AHI (REG_AHI),
      .REG_SEG (REG_SEG),
      .RD_REG  (RD_REG)
   ) u_regs (
      .clk      (clk),
      .rst_n    (rst_n),
      .cfg_sel  (cfg_sel),
      .cfg_wr   (cfg_wr),
      .cfg_addr (cfg_addr),
      .cfg_wdata(cfg_wdata),
      .cfg_rdata(cfg_rdata),
      .win_base (win_base),
      .win_seg  (win_seg)
   );

   bpwin_seq #(
      .ADDR_W(ADDR_W),
      .APER_W(APER_W)
   ) u_seq (
      .clk      (clk),
      .rst_n    (rst_n),
      .win_base (win_base),
      .win_seg  (win_seg),
      .hst_req  (hst_req),
      .hst_wr   (hst_wr),
      .hst_size (hst_size),
      .hst_off  (hst_off),
      .hst_wdata(hst_wdata),
      .hst_rdata(hst_rdata),
      .hst_done (hst_done),
      .bp_valid (bp_valid),
      .bp_ready (bp_ready),
      .bp_wr    (bp_wr),
      .bp_half  (bp_half),
      .bp_addr  (bp_addr),
      .bp_wdata (bp_wdata),
      .bp_rdata (bp_rdata)
   );

   assign win_core = win_base - ENUM_BASE[ADDR_W-1:CORE_W];
endmodule

// File: rtl/bpwin_chk.sv
module bpwin_chk #(
   parameter logic [7:0] SEG_OFF = 8'h34
) (
   input logic        clk,
   input logic        rst_n,
   input logic        cfg_sel,
   input logic        cfg_wr,
   input logic [7:0]  cfg_addr,
   input logic [7:0]  cfg_wdata,
   input logic        seg_now,
   input logic        hst_req,
   input logic        hst_done,
   input logic        bp_valid,
   input logic        bp_ready,
   input logic [31:0] bp_addr,
   input logic [15:0] bp_wdata
);
   logic seg_wr;
   assign seg_wr = cfg_sel && cfg_wr && (cfg_addr == SEG_OFF);

   AST_SEG_IGNORE_BAD: assert property (@(posedge clk) disable iff (!rst_n)
      (seg_wr && cfg_wdata > 8'd1) |=> $stable(seg_now)); // R4

   AST_SEG_TAKE_GOOD: assert property (@(posedge clk) disable iff (!rst_n)
      (seg_wr && cfg_wdata <= 8'd1) |=> (seg_now == $past(cfg_wdata[0]))); // R4

   AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (bp_valid && !bp_ready) |=> (bp_valid && $stable(bp_addr) && $stable(bp_wdata))); // R8

   AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      hst_done |=> !hst_done); // R8

   AST_DONE_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
      hst_done |-> $past(bp_valid && bp_ready)); // R8

   AST_REQ_BEHIND_VALID: assert property (@(posedge clk) disable iff (!rst_n)
      bp_valid |-> hst_req); // R8
endmodule

bind bpwin_mapper bpwin_chk #(.SEG_OFF(REG_SEG)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .cfg_sel  (cfg_sel),
   .cfg_wr   (cfg_wr),
   .cfg_addr (cfg_addr),
   .cfg_wdata(cfg_wdata),
   .seg_now  (u_regs.seg_q),
   .hst_req  (hst_req),
   .hst_done (hst_done),
   .bp_valid (bp_valid),
   .bp_ready (bp_ready),
   .bp_addr  (bp_addr),
   .bp_wdata (bp_wdata)
);

// File: tb/bpwin_mapper_test.sv
`timescale 1ns/1ps
module bpwin_mapper_test;
   localparam logic [7:0] A_LO = 8'h2E, A_MID = 8'h30, A_HI = 8'h32, A_SEG = 8'h34;

   typedef struct packed {
      logic        wr;
      logic [1:0]  sz;
      logic        seg;
      logic [7:0]  rlo;
      logic [7:0]  rmid;
      logic [7:0]  rhi;
      logic [10:0] off;
      logic [31:0] wd;
      logic [2:0]  dly;
   } vec_t;

   localparam int NV = 6;
   localparam vec_t VT [NV] = '{
      '{1'b1, 2'd0, 1'b0, 8'h01, 8'h00, 8'h18, 11'h005, 32'h0000_00AB, 3'd0},
      '{1'b0, 2'd0, 1'b1, 8'h02, 8'h34, 8'h56, 11'h7FF, 32'h0,         3'd2},
      '{1'b1, 2'd1, 1'b0, 8'h0F, 8'hFF, 8'hFF, 11'h102, 32'h0000_BEEF, 3'd1},
      '{1'b0, 2'd1, 1'b1, 8'h03, 8'h00, 8'h18, 11'h010, 32'h0,         3'd1},
      '{1'b1, 2'd2, 1'b1, 8'h05, 8'h12, 8'h18, 11'h200, 32'hCAFE_1234, 3'd0},
      '{1'b0, 2'd2, 1'b0, 8'h0A, 8'hC0, 8'h18, 11'h7FC, 32'h0,         3'd3}
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_sel = 1'b0, cfg_wr = 1'b0;
   logic [7:0]  cfg_addr = '0, cfg_wdata = '0;
   logic [7:0]  cfg_rdata;
   logic        hst_req = 1'b0, hst_wr = 1'b0;
   logic [1:0]  hst_size = '0;
   logic [10:0] hst_off = '0;
   logic [31:0] hst_wdata = '0;
   logic [31:0] hst_rdata;
   logic        hst_done, bp_valid, bp_wr, bp_half;
   logic        bp_ready = 1'b0;
   logic [31:0] bp_addr;
   logic [15:0] bp_wdata;
   logic [15:0] bp_rdata = '0;
   logic [19:0] win_core;

   int nchk = 0, nerr = 0;
   int bp_delay = 0, wcnt = 0, log_n = 0;
   logic [31:0] log_addr [4];
   logic [15:0] log_wd   [4];
   logic        log_half [4];
   logic        log_wr   [4];

   always #2 clk = ~clk;

   bpwin_mapper #(.ENUM_BASE(32'h1800_0000), .RD_REG(1'b0)) uut (
      .clk(clk), .rst_n(rst_n),
      .cfg_sel(cfg_sel), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr),
      .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
      .hst_req(hst_req), .hst_wr(hst_wr), .hst_size(hst_size), .hst_off(hst_off),
      .hst_wdata(hst_wdata), .hst_rdata(hst_rdata), .hst_done(hst_done),
      .bp_valid(bp_valid), .bp_ready(bp_ready), .bp_wr(bp_wr), .bp_half(bp_half),
      .bp_addr(bp_addr), .bp_wdata(bp_wdata), .bp_rdata(bp_rdata),
      .win_core(win_core)
   );

   function automatic logic [15:0] mem_f(input logic [31:0] a);
      return a[15:0] ^ 16'h5A3C;
   endfunction

   // Backplane model: accepts after bp_delay wait cycles and logs each request.
   always @(negedge clk) begin
      if (bp_ready) begin
         bp_ready = 1'b0;
         wcnt = 0;
      end
      if (bp_valid) begin
         if (wcnt >= bp_delay) begin
            bp_ready = 1'b1;
            bp_rdata = mem_f(bp_addr);
            if (log_n < 4) begin
               log_addr[log_n] = bp_addr;
               log_wd[log_n]   = bp_wdata;
               log_half[log_n] = bp_half;
               log_wr[log_n]   = bp_wr;
            end
            log_n++;
         end else begin
            wcnt++;
         end
      end
   end

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      nchk++;
      if (act !== exp) begin
         nerr++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic cfg_write(input logic [7:0] a, input logic [7:0] d);
      @(negedge clk);
      cfg_sel = 1'b1; cfg_wr = 1'b1; cfg_addr = a; cfg_wdata = d;
      @(negedge clk);
      cfg_sel = 1'b0; cfg_wr = 1'b0;
   endtask

   task automatic cfg_read(input logic [7:0] a, output logic [7:0] d);
      @(negedge clk);
      cfg_sel = 1'b1; cfg_wr = 1'b0; cfg_addr = a;
      #1 d = cfg_rdata;
      cfg_sel = 1'b0;
   endtask

   task automatic host_go(input logic w, input logic [1:0] s, input logic [10:0] o,
                          input logic [31:0] d);
      log_n = 0;
      @(negedge clk);
      hst_req = 1'b1; hst_wr = w; hst_size = s; hst_off = o; hst_wdata = d;
   endtask

   task automatic host_wait(output logic [31:0] rd);
      int t = 0;
      forever begin
         @(negedge clk);
         if (hst_done) break;
         t++;
         if (t > 200) begin
            nerr++;
            $display("FAIL R8: access never completed, actual 0 expected 1");
            break;
         end
      end
      rd = hst_rdata;
      hst_req = 1'b0;
   endtask

   task automatic finish_run;
      $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
      $finish;
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      nerr++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      logic [7:0]  rb;
      logic [31:0] rd, a0, exp_rd;
      repeat (3) @(posedge clk);
      @(negedge clk) rst_n = 1'b1;

      // R1: reset state
      cfg_read(A_LO, rb);  chk("R1 alo reset", {24'd0, rb}, 32'h0);
      cfg_read(A_MID, rb); chk("R1 amid reset", {24'd0, rb}, 32'h0);
      cfg_read(A_HI, rb);  chk("R1 ahi reset", {24'd0, rb}, 32'h0);
      cfg_read(A_SEG, rb); chk("R1 seg reset", {24'd0, rb}, 32'h0);
      chk("R1 bp_valid idle", {31'd0, bp_valid}, 32'h0);
      chk("R1 hst_done idle", {31'd0, hst_done}, 32'h0);
      chk("R1 win_core reset", {12'd0, win_core}, 32'h000E_8000);

      // Vector table walk: R5, R6, R7
      for (int i = 0; i < NV; i++) begin
         cfg_write(A_LO, VT[i].rlo);
         cfg_write(A_MID, VT[i].rmid);
         cfg_write(A_HI, VT[i].rhi);
         cfg_write(A_SEG, {7'd0, VT[i].seg});
         bp_delay = int'(VT[i].dly);
         host_go(VT[i].wr, VT[i].sz, VT[i].off, VT[i].wd);
         host_wait(rd);
         a0 = {VT[i].rhi, VT[i].rmid, VT[i].rlo[3:0], VT[i].seg, VT[i].off};
         if (VT[i].sz == 2'd2) begin
            chk("R6 request count", log_n, 2);
            chk("R6 low half addr", log_addr[0], a0);
            chk("R6 high half addr", log_addr[1], a0 + 32'd2);
            chk("R6 halves 16-bit", {30'd0, log_half[0], log_half[1]}, 32'h3);
            if (VT[i].wr) begin
               chk("R6 low half data", {16'd0, log_wd[0]}, {16'd0, VT[i].wd[15:0]});
               chk("R6 high half data", {16'd0, log_wd[1]}, {16'd0, VT[i].wd[31:16]});
            end else begin
               chk("R6 assembled read", rd, {mem_f(a0 + 32'd2), mem_f(a0)});
            end
         end else begin
            chk("R5 request count", log_n, 1);
            chk("R5 address", log_addr[0], a0);
            chk("R5 size flag", {31'd0, log_half[0]}, {31'd0, VT[i].sz[0]});
            chk("R5 direction", {31'd0, log_wr[0]}, {31'd0, VT[i].wr});
            if (VT[i].wr) begin
               if (VT[i].sz == 2'd0)
                  chk("R5 byte data", {24'd0, log_wd[0][7:0]}, {24'd0, VT[i].wd[7:0]});
               else
                  chk("R5 half data", {16'd0, log_wd[0]}, {16'd0, VT[i].wd[15:0]});
            end else begin
               exp_rd = (VT[i].sz == 2'd0) ? {24'd0, mem_f(a0)[7:0]} : {16'd0, mem_f(a0)};
               chk("R7 zero-extended read", rd, exp_rd);
            end
         end
      end

      // R2: low address register keeps only its low nibble
      cfg_write(A_LO, 8'hFF);
      cfg_read(A_LO, rb); chk("R2 nibble readback", {24'd0, rb}, 32'h0F);
      // R3: full byte registers and unmapped offsets
      cfg_write(A_MID, 8'hA7);
      cfg_write(A_HI, 8'h3C);
      cfg_read(A_MID, rb); chk("R3 mid readback", {24'd0, rb}, 32'hA7);
      cfg_read(A_HI, rb);  chk("R3 high readback", {24'd0, rb}, 32'h3C);
      cfg_write(8'h40, 8'h99);
      cfg_read(8'h40, rb); chk("R3 unmapped reads zero", {24'd0, rb}, 32'h0);
      cfg_read(A_MID, rb); chk("R3 unmapped write harmless", {24'd0, rb}, 32'hA7);

      // R4: only 0 and 1 are accepted by the segment register
      cfg_write(A_SEG, 8'h01);
      cfg_read(A_SEG, rb); chk("R4 seg accepts 1", {24'd0, rb}, 32'h1);
      cfg_write(A_SEG, 8'h02);
      cfg_read(A_SEG, rb); chk("R4 seg ignores 2", {24'd0, rb}, 32'h1);
      cfg_write(A_SEG, 8'h00);
      cfg_write(A_SEG, 8'hFF);
      cfg_read(A_SEG, rb); chk("R4 seg ignores FF", {24'd0, rb}, 32'h0);

      // R10: core index from base registers
      cfg_write(A_LO, 8'h03);
      cfg_write(A_MID, 8'h00);
      cfg_write(A_HI, 8'h18);
      chk("R10 core index 3", {12'd0, win_core}, 32'h3);
      cfg_write(A_LO, 8'h04);
      chk("R10 core index 4", {12'd0, win_core}, 32'h4);

      // R9: reprogramming during a stalled 32-bit access
      cfg_write(A_SEG, 8'h00);
      bp_delay = 7;
      host_go(1'b0, 2'd2, 11'h010, 32'h0);
      cfg_write(A_LO, 8'h09);
      cfg_write(A_MID, 8'h77);
      cfg_write(A_HI, 8'h20);
      cfg_write(A_SEG, 8'h01);
      host_wait(rd);
      chk("R9 first half keeps old window", log_addr[0], 32'h1800_4010);
      chk("R9 second half keeps old window", log_addr[1], 32'h1800_4012);
      chk("R8 read after long stall", rd, {mem_f(32'h1800_4012), mem_f(32'h1800_4010)});
      bp_delay = 0;
      host_go(1'b0, 2'd0, 11'h000, 32'h0);
      host_wait(rd);
      chk("R9 next access uses new window", log_addr[0], 32'h2077_9800);
      @(negedge clk);
      chk("R8 done is a single pulse", {31'd0, hst_done}, 32'h0);

      finish_run();
   end
endmodule